// File: doc/BRIEF.md
# One-Hot Coded Integer ALU

This block is the purely combinational arithmetic and logic unit of a pipelined execute stage. Two operand words, a shift distance and a ten-bit operation word enter, and one result word plus a zero indication leave in the same cycle. Nothing inside holds state, so the stage around it decides when the result is captured.

The operation word holds a one-hot select field and one extra control bit. That bit steers a single ripple-carry adder: when set, the second operand is inverted and the carry into the lowest stage is forced high, so the adder yields A minus B. Subtraction, both comparison modes and equality tests for branches all reuse that one adder. Shifts and the upper-immediate load act on operand B, and the shifts take their distance from the separate shift-amount input.

Operation word layout: bit 0 is the control bit, bits 9..1 are the select field with ADD/SUB at bit 1, then OR, AND, NOR, SLT, SLTU, SLL, SRL, and LUI at bit 9.

Top module: `onehot_alu`

## Requirements
- R1: Operation word 0x002 (ADD) gives result = A + B modulo 2^32.
- R2: Operation word 0x003 (SUB, control bit set) gives result = A - B modulo 2^32, built as A plus inverted B with carry-in 1.
- R3: Operation words 0x004, 0x008 and 0x010 give bitwise A|B, A&B and ~(A|B) respectively.
- R4: Operation word 0x021 (SLT) gives 1 when A is less than B as two's-complement numbers, else 0, including when A - B overflows.
- R5: Operation word 0x041 (SLTU) gives 1 when A is less than B as unsigned numbers, else 0.
- R6: Operation word 0x080 (SLL) gives B shifted left by the shift-amount input, zeros filling from the right.
- R7: Operation word 0x100 (SRL) gives B shifted right by the shift-amount input, zeros filling from the left.
- R8: Operation word 0x200 (LUI) gives the low 16 bits of B placed in the upper half, lower half zero.
- R9: The zero output is 1 exactly when the result is all zeros; under SUB it is therefore 1 exactly when A equals B.
- R10: Any operation word other than the ten codes listed in R1 to R8 (a select field that is not one-hot, or a control bit that does not match its select) gives result 0 and zero output 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 32 | First operand |
| b_i | input | 32 | Second operand; source for shifts and LUI |
| shamt_i | input | 5 | Shift distance for SLL and SRL |
| op_i | input | 10 | Operation word: bit 0 control, bits 9..1 one-hot select |
| result_o | output | 32 | Result of the selected operation |
| zero_o | output | 1 | High when result_o is all zeros |

## Verification
With no stored state, a fault in the carry chain, the inversion path, the shifter stages or the decoder shows at result_o and zero_o in the same evaluation as the inputs that exercise it. A broken inversion or carry-in shows as SUB and SLT results off by one or by the value of B, a broken overflow term shows only for operand pairs of opposite sign whose difference overflows, and a shifter stage fault shows only for distances that use that stage. Random operands over all ten codes are mixed with directed pairs at the sign boundary, equal operands, shift distances 0 and 31, and malformed operation words.

// File: rtl/onehot_alu_pkg.sv
// Package: operation-word layout shared by the ALU, its checker and users.
// Assumes the select field sits directly above the control bit.
package onehot_alu_pkg;
    localparam int SEL_W = 9;
    localparam int OPW   = SEL_W + 1;

    // Bit positions inside the select field (order is part of the encoding)
    localparam int S_ADD  = 0;
    localparam int S_OR   = 1;
    localparam int S_AND  = 2;
    localparam int S_NOR  = 3;
    localparam int S_SLT  = 4;
    localparam int S_SLTU = 5;
    localparam int S_SLL  = 6;
    localparam int S_SRL  = 7;
    localparam int S_LUI  = 8;

    // Selects whose control bit must be 1; ADD/SUB accepts either value
    localparam logic [SEL_W-1:0] NEED_CTRL = (SEL_W'(1) << S_SLT) | (SEL_W'(1) << S_SLTU);
    localparam logic [SEL_W-1:0] FREE_CTRL = SEL_W'(1) << S_ADD;

    // Full operation words
    localparam logic [OPW-1:0] OPC_ADD  = OPW'(1) << (S_ADD + 1);
    localparam logic [OPW-1:0] OPC_SUB  = (OPW'(1) << (S_ADD + 1)) | OPW'(1);
    localparam logic [OPW-1:0] OPC_OR   = OPW'(1) << (S_OR + 1);
    localparam logic [OPW-1:0] OPC_AND  = OPW'(1) << (S_AND + 1);
    localparam logic [OPW-1:0] OPC_NOR  = OPW'(1) << (S_NOR + 1);
    localparam logic [OPW-1:0] OPC_SLT  = (OPW'(1) << (S_SLT + 1)) | OPW'(1);
    localparam logic [OPW-1:0] OPC_SLTU = (OPW'(1) << (S_SLTU + 1)) | OPW'(1);
    localparam logic [OPW-1:0] OPC_SLL  = OPW'(1) << (S_SLL + 1);
    localparam logic [OPW-1:0] OPC_SRL  = OPW'(1) << (S_SRL + 1);
    localparam logic [OPW-1:0] OPC_LUI  = OPW'(1) << (S_LUI + 1);
endpackage

// File: rtl/alu_op_decode.sv
// Operation decoder: validates the operation word and passes on a clean
// one-hot select plus the adder invert/carry control. Assumes the layout
// in onehot_alu_pkg. An invalid word produces an all-zero select.
module alu_op_decode
    import onehot_alu_pkg::*;
(
    input  logic [OPW-1:0]   op_i,
    output logic [SEL_W-1:0] sel_o,
    output logic             inv_o
);
    logic [SEL_W-1:0] sel_raw;
    logic             ctrl;
    logic             ctrl_ok;
    logic             valid;

    assign sel_raw = op_i[OPW-1:1];
    assign ctrl    = op_i[0];

    // Purpose: accept only one-hot selects whose control bit fits the select
    always_comb begin
        ctrl_ok = ((sel_raw & FREE_CTRL) != '0) || (ctrl == ((sel_raw & NEED_CTRL) != '0));
        valid   = $onehot(sel_raw) && ctrl_ok;
        sel_o   = valid ? sel_raw : '0;
        inv_o   = valid & ctrl;
    end
endmodule

// File: rtl/alu_ripple_adder.sv
// Ripple-carry adder with optional inversion of B. The invert input also
// drives the carry into bit 0, so invert=1 yields A - B. Reports carry-out
// and signed overflow (carry into MSB differs from carry out of MSB).
module alu_ripple_adder #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic             inv_i,
    output logic [WIDTH-1:0] sum_o,
    output logic             cout_o,
    output logic             ovf_o
);
    logic [WIDTH:0]   carry;
    logic [WIDTH-1:0] b_eff;

    assign carry[0] = inv_i;
    assign b_eff    = inv_i ? ~b_i : b_i;

    // One full adder per bit, chained through carry
    for (genvar i = 0; i < WIDTH; i++) begin : g_fa
        assign sum_o[i]   = a_i[i] ^ b_eff[i] ^ carry[i];
        assign carry[i+1] = (a_i[i] & b_eff[i]) | (carry[i] & (a_i[i] ^ b_eff[i]));
    end

    assign cout_o = carry[WIDTH];
    assign ovf_o  = carry[WIDTH] ^ carry[WIDTH-1];
endmodule

// File: rtl/alu_shifter.sv
// Logarithmic logical shifter. Shifts right natively; a left shift is done
// by bit-reversing the input and the output. Zeros fill vacated bits.
module alu_shifter #(
    parameter int WIDTH = 32,
    parameter int SHW   = $clog2(WIDTH)
) (
    input  logic [WIDTH-1:0] data_i,
    input  logic [SHW-1:0]   amt_i,
    input  logic             left_i,
    output logic [WIDTH-1:0] data_o
);
    logic [WIDTH-1:0] rev_in;
    logic [WIDTH-1:0] rev_out;
    logic [WIDTH-1:0] stage [SHW+1];

    // Bit reversal of input and of final stage
    for (genvar i = 0; i < WIDTH; i++) begin : g_rev
        assign rev_in[i]  = data_i[WIDTH-1-i];
        assign rev_out[i] = stage[SHW][WIDTH-1-i];
    end

    assign stage[0] = left_i ? rev_in : data_i;

    // Stage s moves the word right by 2**s when amount bit s is set
    for (genvar s = 0; s < SHW; s++) begin : g_stage
        assign stage[s+1] = amt_i[s] ? (stage[s] >> (1 << s)) : stage[s];
    end

    assign data_o = left_i ? rev_out : stage[SHW];
endmodule

// File: rtl/onehot_alu.sv
// Top: combinational ALU steered by a one-hot operation word. Combines the
// decoder, the shared adder, the shifter and the bitwise logic with an
// AND-OR result mux. Assumes WIDTH is even (LUI uses the halves).
module onehot_alu
    import onehot_alu_pkg::*;
#(
    parameter int WIDTH   = 32,
    parameter int SHAMT_W = $clog2(WIDTH)
) (
    input  logic [WIDTH-1:0]   a_i,
    input  logic [WIDTH-1:0]   b_i,
    input  logic [SHAMT_W-1:0] shamt_i,
    input  logic [OPW-1:0]     op_i,
    output logic [WIDTH-1:0]   result_o,
    output logic               zero_o
);
    localparam int HALF = WIDTH / 2;

    logic [SEL_W-1:0] sel;
    logic             inv;
    logic [WIDTH-1:0] sum;
    logic             cout;
    logic             ovf;
    logic [WIDTH-1:0] shifted;
    logic             lt_s;
    logic             lt_u;

    alu_op_decode u_dec (
        .op_i  (op_i),
        .sel_o (sel),
        .inv_o (inv)
    );

    alu_ripple_adder #(.WIDTH(WIDTH)) u_add (
        .a_i    (a_i),
        .b_i    (b_i),
        .inv_i  (inv),
        .sum_o  (sum),
        .cout_o (cout),
        .ovf_o  (ovf)
    );

    alu_shifter #(.WIDTH(WIDTH), .SHW(SHAMT_W)) u_shf (
        .data_i (b_i),
        .amt_i  (shamt_i),
        .left_i (sel[S_SLL]),
        .data_o (shifted)
    );

    // Purpose: derive comparison outcomes from the subtracting adder
    always_comb begin
        lt_s = sum[WIDTH-1] ^ ovf;
        lt_u = ~cout;
    end

    // Purpose: gate each candidate by its select bit and merge
    always_comb begin
        result_o = ({WIDTH{sel[S_ADD]}}  & sum)
                 | ({WIDTH{sel[S_OR]}}   & (a_i | b_i))
                 | ({WIDTH{sel[S_AND]}}  & (a_i & b_i))
                 | ({WIDTH{sel[S_NOR]}}  & ~(a_i | b_i))
                 | ({WIDTH{sel[S_SLT]}}  & {{(WIDTH-1){1'b0}}, lt_s})
                 | ({WIDTH{sel[S_SLTU]}} & {{(WIDTH-1){1'b0}}, lt_u})
                 | ({WIDTH{sel[S_SLL] | sel[S_SRL]}} & shifted)
                 | ({WIDTH{sel[S_LUI]}}  & {b_i[HALF-1:0], {HALF{1'b0}}});
        zero_o   = (result_o == '0);
    end
endmodule

// File: rtl/onehot_alu_checker.sv
// Checker: relates the ALU's ports for each operation code. Bound to every
// onehot_alu instance. Combinational block, so immediate assertions only.
module onehot_alu_checker
    import onehot_alu_pkg::*;
#(
    parameter int WIDTH   = 32,
    parameter int SHAMT_W = $clog2(WIDTH)
) (
    input logic [WIDTH-1:0]   a_i,
    input logic [WIDTH-1:0]   b_i,
    input logic [SHAMT_W-1:0] shamt_i,
    input logic [OPW-1:0]     op_i,
    input logic [WIDTH-1:0]   result_o,
    input logic               zero_o
);
    // Purpose: check each operation's result against an arithmetic identity
    always_comb begin
        if (op_i == OPC_ADD)
            a_r1_add_inverse: assert (result_o - b_i == a_i) else $error("R1 add mismatch");
        if (op_i == OPC_SUB)
            a_r2_sub_inverse: assert (result_o + b_i == a_i) else $error("R2 sub mismatch");
        if (op_i == OPC_NOR)
            a_r3_nor_disjoint: assert ((result_o & (a_i | b_i)) == '0) else $error("R3 nor mismatch");
        if (op_i == OPC_SLT)
            a_r4_slt_signed: assert (result_o == WIDTH'($signed(a_i) < $signed(b_i))) else $error("R4 slt mismatch");
        if (op_i == OPC_SLTU)
            a_r5_sltu_unsigned: assert (result_o == WIDTH'(a_i < b_i)) else $error("R5 sltu mismatch");
        if (op_i == OPC_SLL)
            a_r6_sll_back: assert ((result_o >> shamt_i) == ((b_i << shamt_i) >> shamt_i)) else $error("R6 sll mismatch");
        if (op_i == OPC_LUI)
            a_r8_lui_low_zero: assert (result_o[WIDTH/2-1:0] == '0) else $error("R8 lui mismatch");
        if (op_i == OPC_SUB)
            a_r9_eq_zero: assert (zero_o == (a_i == b_i)) else $error("R9 zero mismatch");
        if (!$onehot(op_i[OPW-1:1]))
            a_r10_invalid_zero: assert (result_o == '0 && zero_o) else $error("R10 invalid mismatch");
    end
endmodule

bind onehot_alu onehot_alu_checker #(.WIDTH(WIDTH), .SHAMT_W(SHAMT_W)) u_checker (
    .a_i      (a_i),
    .b_i      (b_i),
    .shamt_i  (shamt_i),
    .op_i     (op_i),
    .result_o (result_o),
    .zero_o   (zero_o)
);

// File: tb/onehot_alu_bench.sv
module onehot_alu_bench;
    logic        clk = 1'b0;
    logic [31:0] a, b;
    logic [4:0]  sh;
    logic [9:0]  op;
    logic [31:0] res;
    logic        zf;
    int          checks = 0;
    int          errors = 0;
    bit          done = 0;

    always #4 clk = ~clk;

    onehot_alu u_onehot_alu (
        .a_i      (a),
        .b_i      (b),
        .shamt_i  (sh),
        .op_i     (op),
        .result_o (res),
        .zero_o   (zf)
    );

    function automatic logic [31:0] model(input logic [31:0] x, input logic [31:0] y,
                                          input logic [4:0] s, input logic [9:0] o);
        case (o)
            10'h002: return x + y;
            10'h003: return x - y;
            10'h004: return x | y;
            10'h008: return x & y;
            10'h010: return ~(x | y);
            10'h021: return {31'd0, $signed(x) < $signed(y)};
            10'h041: return {31'd0, x < y};
            10'h080: return y << s;
            10'h100: return y >> s;
            10'h200: return {y[15:0], 16'h0000};
            default: return 32'h0;
        endcase
    endfunction

    function automatic string req_of(input logic [9:0] o);
        case (o)
            10'h002: return "R1";
            10'h003: return "R2";
            10'h004, 10'h008, 10'h010: return "R3";
            10'h021: return "R4";
            10'h041: return "R5";
            10'h080: return "R6";
            10'h100: return "R7";
            10'h200: return "R8";
            default: return "R10";
        endcase
    endfunction

    task automatic run(input logic [31:0] x, input logic [31:0] y,
                       input logic [4:0] s, input logic [9:0] o);
        logic [31:0] exp_r;
        @(negedge clk);
        a = x; b = y; sh = s; op = o;
        #1;
        exp_r = model(x, y, s, o);
        checks++;
        if (res !== exp_r) begin
            errors++;
            $display("FAIL %s op=%h a=%h b=%h sh=%0d result got %h expected %h",
                     req_of(o), o, x, y, s, res, exp_r);
        end
        checks++;
        if (zf !== (exp_r == 32'h0)) begin
            errors++;
            $display("FAIL R9 op=%h a=%h b=%h zero got %b expected %b",
                     o, x, y, zf, exp_r == 32'h0);
        end
    endtask

    initial begin
        logic [9:0] codes [10];
        void'($urandom(32'd1234));
        codes = '{10'h002, 10'h003, 10'h004, 10'h008, 10'h010,
                  10'h021, 10'h041, 10'h080, 10'h100, 10'h200};
        // idle state: all-zero word counts as invalid (R10)
        run(32'h1234_5678, 32'h9abc_def0, 5'd3, 10'h000);
        // R1 wrap-around and R2 borrow
        run(32'hffff_ffff, 32'h0000_0001, 5'd0, 10'h002);
        run(32'h0000_0000, 32'h0000_0001, 5'd0, 10'h003);
        // R9 equal operands under SUB give zero
        run(32'hdead_beef, 32'hdead_beef, 5'd0, 10'h003);
        // R4 overflow cases and sign boundary
        run(32'h8000_0000, 32'h0000_0001, 5'd0, 10'h021);
        run(32'h7fff_ffff, 32'hffff_ffff, 5'd0, 10'h021);
        run(32'hffff_ffff, 32'h0000_0000, 5'd0, 10'h021);
        run(32'h5555_5555, 32'h5555_5555, 5'd0, 10'h021);
        // R5 unsigned view of the same pairs
        run(32'h8000_0000, 32'h0000_0001, 5'd0, 10'h041);
        run(32'h0000_0000, 32'hffff_ffff, 5'd0, 10'h041);
        run(32'h0000_0007, 32'h0000_0007, 5'd0, 10'h041);
        // R6/R7 extreme distances
        run(32'h0, 32'h8000_0001, 5'd0, 10'h080);
        run(32'h0, 32'h8000_0001, 5'd31, 10'h080);
        run(32'h0, 32'h8000_0001, 5'd31, 10'h100);
        run(32'h0, 32'hf000_000f, 5'd4, 10'h100);
        // R8 upper half loading
        run(32'h0, 32'hffff_a5a5, 5'd0, 10'h200);
        // R3 on complementary patterns
        run(32'haaaa_aaaa, 32'h5555_5555, 5'd0, 10'h004);
        run(32'haaaa_aaaa, 32'h5555_5555, 5'd0, 10'h008);
        run(32'haaaa_aaaa, 32'h5555_5555, 5'd0, 10'h010);
        // R10 control-bit mismatch and multiple selects
        run(32'h1, 32'h2, 5'd1, 10'h005);
        run(32'h1, 32'h2, 5'd1, 10'h020);
        run(32'h1, 32'h2, 5'd1, 10'h006);
        run(32'h1, 32'h2, 5'd1, 10'h201);
        // random legal codes
        for (int i = 0; i < 3000; i++)
            run($urandom, $urandom, 5'($urandom), codes[$urandom % 10]);
        // random arbitrary words (mostly invalid, R10)
        for (int i = 0; i < 500; i++)
            run($urandom, $urandom, 5'($urandom), 10'($urandom));
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule